// File: doc/BRIEF.md
# Paired-Channel DMA Interrupt Status

This block keeps the event status of every channel of a 16-channel DMA controller and drives one interrupt line per channel. The transfer engine sends single-cycle event pulses for each channel: bus timeout, dropped request, half frame, frame done, last frame started and block done. It also drives a level that shows whether a synchronized channel is currently active. Each channel records these in a sticky status word. A per-channel enable mask decides which of the events are recorded. The dropped-request event is always recorded.

A mode input selects between two layouts. In the legacy layout only nine channels exist. Channels `i` and `i+6` (for `i` below 3) share status and interrupt line `i`, and lines 3 to 5 serve channels 3 to 5 alone. In the extended layout all sixteen channels exist, and each drives its own line. Software reads status through a simple read port: a strobe, a channel number and a register select. Reading the status word clears the event flags and lowers the line. In the legacy layout, reading one member of a pair also returns and clears the other member's flags.

The read result comes back one cycle after the strobe, together with a valid flag. There is no back-pressure: the requester must take the data in the cycle `rd_valid_o` is high. The write port and all control pins are plain levels that are sampled on the clock.

Top module: `dma_evt_irq_status`

## Requirements
- R1: After reset all event flags are 0, every enable mask reads 0x03, all interrupt lines are low and `rd_valid_o` is low.
- R2: Status word layout: bit 0 timeout, bit 1 dropped request, bit 2 half frame, bit 3 frame done, bit 4 last frame, bit 5 block done, bit 6 sync-active. Event input bit k of a channel (`evt_i[6*ch+k]`) sets status bit k on the next clock edge, and the bit stays set until a status read clears it.
- R3: Event bits 0, 2, 3, 4 and 5 are recorded only when enable-mask bit k of that channel is 1.
- R4: The dropped-request event (bit 1) is recorded whatever the enable mask holds.
- R5: Status bit 6 follows `sync_act_i` of the channel with one cycle of delay and is not changed by reads.
- R6: A read strobe gives `rd_valid_o` high exactly one cycle later. `rd_sel_i`=0 selects the status word; `rd_sel_i`=1 returns the enable mask in bits 5:0 with no side effect.
- R7: A status read returns the status word as it was before the read, then clears bits 5:0 of that channel.
- R8: In legacy mode, a status read of channel 0, 1, 2, 6, 7 or 8 ORs the partner's bits 5:0 into read bits 11:6 and also clears the partner's bits 5:0. In extended mode, read bits 15:7 are 0.
- R9: Legacy mode: line l (l<3) is high when channel l or channel l+6 has a nonzero status word, lines 3 to 5 follow their own channel, and lines 6 to 15 are low. Extended mode: line l is high when channel l's status word is nonzero.
- R10: Interrupt lines are registered and change one cycle after the status change that causes them.
- R11: A status read drives low, one cycle later, the line that serves the channel. The line rises again one cycle after that if the status word is still nonzero.
- R12: An event that arrives in the same cycle as a clearing status read remains set after the read.
- R13: A write with `wr_sel_i`=1 loads the channel's enable mask from `wr_data_i`. A write with `wr_sel_i`=0 targets the status word and changes nothing.
- R14: In legacy mode, channels 9 to 15 do not exist: their events and writes are ignored, and reads of them return 0 with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode_i | input | 1 | 1 = extended layout, 0 = legacy paired layout |
| evt_i | input | 96 | Event pulses, 6 bits per channel, channel c at bits 6c+5:6c |
| sync_act_i | input | 16 | Sync-active level per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 4 | Write channel number |
| wr_sel_i | input | 1 | 1 = enable mask, 0 = status word (ignored) |
| wr_data_i | input | 6 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_ch_i | input | 4 | Read channel number |
| rd_sel_i | input | 1 | 0 = status word (clearing), 1 = enable mask |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | 16 | Read data |
| irq_o | output | 16 | Interrupt lines |

## Verification
On every cycle the assertions check these properties: a dropped request is always recorded, a masked event never appears, and a clear with no new event leaves bits 5:0 empty. They also check that an event which collides with a clear survives, that read valid follows the strobe, that no partner bits appear in extended mode, that a lowered line is low one cycle later, and that lines 6 to 15 stay quiet in legacy mode. Some behaviours need a reference model and directed sequences: the exact read data including the partner field, which channel gets cleared and which line goes low, the sync bit surviving a read and re-raising the line, masking changed by writes, and channels that are absent in legacy mode.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int EVT_W    = 6;
  localparam int STAT_W   = 7;
  localparam int RD_W     = 16;
  localparam int BIT_TMO  = 0;
  localparam int BIT_DROP = 1;
  localparam int BIT_HALF = 2;
  localparam int BIT_FRM  = 3;
  localparam int BIT_LAST = 4;
  localparam int BIT_BLK  = 5;
  localparam int BIT_SYNC = 6;
  localparam int PART_LSB = 6;
  localparam logic [EVT_W-1:0] IEN_RESET = 6'h03;
  localparam logic [EVT_W-1:0] ALWAYS_ON = 6'h02;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  function automatic bit has_partner(int c, int span, int pairs);
    return (c < pairs) || (c >= span && c < span + pairs);
  endfunction

  function automatic int partner_of(int c, int span, int pairs);
    return (c < pairs) ? c + span : c - span;
  endfunction
endpackage

// File: rtl/irqst_chan.sv
module irqst_chan
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              sync_i,
  input  logic              ien_we_i,
  input  logic [EVT_W-1:0]  ien_wdata_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic [EVT_W-1:0]  ien_o
);
  logic [EVT_W-1:0] flags_q;
  logic [EVT_W-1:0] ien_q;
  logic             sync_q;
  logic [EVT_W-1:0] accepted;

  // the dropped-request event bypasses the mask
  assign accepted = present_i ? (evt_i & (ien_q | ALWAYS_ON)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= IEN_RESET;
      sync_q  <= 1'b0;
    end else begin
      flags_q <= (clr_i ? '0 : flags_q) | accepted;
      if (ien_we_i) ien_q <= ien_wdata_i;
      sync_q  <= sync_i;
    end
  end

  assign status_o = {sync_q, flags_q};
  assign ien_o    = ien_q;

  a_r4_drop_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    present_i && evt_i[BIT_DROP] |=> status_o[BIT_DROP]);

  a_r3_masked_half_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[BIT_HALF] && !ien_o[BIT_HALF] && !status_o[BIT_HALF] |=> !status_o[BIT_HALF]);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !(present_i && |evt_i) |=> status_o[EVT_W-1:0] == '0);

  a_r12_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && present_i && evt_i[BIT_DROP] |=> status_o[BIT_DROP]);
endmodule

// File: rtl/irqst_read.sv
module irqst_read
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int PAIR_SPAN    = 6,
  parameter int SHARED_PAIRS = 3,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           legacy_i,
  input  logic                           rd_en_i,
  input  logic [CH_W-1:0]                rd_ch_i,
  input  logic                           rd_sel_i,
  input  logic [NUM_CH-1:0]              present_i,
  input  logic [NUM_CH-1:0][STAT_W-1:0]  status_i,
  input  logic [NUM_CH-1:0][EVT_W-1:0]   ien_i,
  output logic [NUM_CH-1:0]              clr_o,
  output logic [NUM_CH-1:0]              lower_o,
  output logic                           rd_valid_o,
  output logic [RD_W-1:0]                rd_data_o
);
  int               rd_idx;
  logic             hit;
  logic             stat_rd;
  logic [EVT_W-1:0] part_flags;
  logic [RD_W-1:0]  rd_next;
  int               line_idx;
  logic             valid_q;
  logic [RD_W-1:0]  data_q;

  always_comb begin
    rd_idx  = int'(rd_ch_i);
    hit     = present_i[rd_ch_i];
    stat_rd = rd_en_i && (rd_sel_i == SEL_STATUS) && hit;
  end

  // partner flags and the clear vector
  always_comb begin
    part_flags = '0;
    clr_o      = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (legacy_i && has_partner(i, PAIR_SPAN, SHARED_PAIRS) &&
          partner_of(i, PAIR_SPAN, SHARED_PAIRS) == rd_idx) begin
        part_flags = status_i[i][EVT_W-1:0];
        clr_o[i]   = stat_rd;
      end
      if (i == rd_idx) clr_o[i] = stat_rd;
    end
  end

  // a legacy pair shares the lower channel's line
  always_comb begin
    line_idx = rd_idx;
    if (legacy_i && rd_idx >= PAIR_SPAN && rd_idx < PAIR_SPAN + SHARED_PAIRS)
      line_idx = rd_idx - PAIR_SPAN;
    lower_o = '0;
    if (stat_rd) lower_o[line_idx] = 1'b1;
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      if (rd_sel_i == SEL_STATUS)
        rd_next = RD_W'(status_i[rd_ch_i]) | (RD_W'(part_flags) << PART_LSB);
      else
        rd_next = RD_W'(ien_i[rd_ch_i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= rd_next;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);

  a_r8_ext_no_partner_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !legacy_i |=> rd_data_o[RD_W-1:STAT_W] == '0);

  a_r8_ext_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_i |-> $countones(clr_o) <= 1);

  a_r11_single_lower: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lower_o));
endmodule

// File: rtl/irqst_lines.sv
module irqst_lines
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int PAIR_SPAN    = 6,
  parameter int SHARED_PAIRS = 3,
  localparam int LEGACY_LINES = PAIR_SPAN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          legacy_i,
  input  logic [NUM_CH-1:0][STAT_W-1:0] status_i,
  input  logic [NUM_CH-1:0]             lower_i,
  output logic [NUM_CH-1:0]             irq_o
);
  logic [NUM_CH-1:0] st_nz;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) st_nz[c] = |status_i[c];
  end

  for (genvar l = 0; l < NUM_CH; l++) begin : g_line
    logic req;
    logic irq_q;
    if (l < SHARED_PAIRS) begin : g_shared
      assign req = legacy_i ? (st_nz[l] | st_nz[l+PAIR_SPAN]) : st_nz[l];
    end else if (l < LEGACY_LINES) begin : g_solo
      assign req = st_nz[l];
    end else begin : g_ext_only
      assign req = legacy_i ? 1'b0 : st_nz[l];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= req & ~lower_i[l];
    end
    assign irq_o[l] = irq_q;

    a_r11_lowered_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      lower_i[l] |=> !irq_o[l]);

    a_r10_ext_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_i && !st_nz[l] |=> !irq_o[l]);

    if (l >= LEGACY_LINES) begin : g_chk_upper
      a_r9_legacy_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !irq_o[l]);
    end
  end
endmodule

// File: rtl/dma_evt_irq_status.sv
module dma_evt_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int LEGACY_CH    = 9,
  parameter int PAIR_SPAN    = 6,
  parameter int SHARED_PAIRS = 3,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ext_mode_i,
  input  logic [NUM_CH*EVT_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]       sync_act_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic                    wr_sel_i,
  input  logic [EVT_W-1:0]        wr_data_i,
  input  logic                    rd_en_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  input  logic                    rd_sel_i,
  output logic                    rd_valid_o,
  output logic [RD_W-1:0]         rd_data_o,
  output logic [NUM_CH-1:0]       irq_o
);
  logic                          legacy;
  logic [NUM_CH-1:0]             present;
  logic [NUM_CH-1:0]             clr;
  logic [NUM_CH-1:0]             lower;
  logic [NUM_CH-1:0][STAT_W-1:0] status;
  logic [NUM_CH-1:0][EVT_W-1:0]  ien;

  assign legacy = !ext_mode_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic we;
    assign present[i] = !legacy || (i < LEGACY_CH);
    assign we = wr_en_i && (wr_ch_i == CH_W'(i)) && (wr_sel_i == SEL_ENABLE) && present[i];

    irqst_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .present_i   (present[i]),
      .evt_i       (evt_i[i*EVT_W +: EVT_W]),
      .sync_i      (sync_act_i[i]),
      .ien_we_i    (we),
      .ien_wdata_i (wr_data_i),
      .clr_i       (clr[i]),
      .status_o    (status[i]),
      .ien_o       (ien[i])
    );
  end

  irqst_read #(
    .NUM_CH       (NUM_CH),
    .PAIR_SPAN    (PAIR_SPAN),
    .SHARED_PAIRS (SHARED_PAIRS)
  ) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacy_i   (legacy),
    .rd_en_i    (rd_en_i),
    .rd_ch_i    (rd_ch_i),
    .rd_sel_i   (rd_sel_i),
    .present_i  (present),
    .status_i   (status),
    .ien_i      (ien),
    .clr_o      (clr),
    .lower_o    (lower),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  irqst_lines #(
    .NUM_CH       (NUM_CH),
    .PAIR_SPAN    (PAIR_SPAN),
    .SHARED_PAIRS (SHARED_PAIRS)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .legacy_i (legacy),
    .status_i (status),
    .lower_i  (lower),
    .irq_o    (irq_o)
  );

  a_r14_absent_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> clr[NUM_CH-1:LEGACY_CH] == '0);
endmodule

// File: tb/test_dma_evt_irq_status.sv
module test_dma_evt_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic [95:0] evt = '0;
  logic [15:0] sync_act = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_ch = '0;
  logic        wr_sel = 1'b0;
  logic [5:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_ch = '0;
  logic        rd_sel = 1'b0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic [15:0] irq_o;

  dma_evt_irq_status i_dma_evt_irq_status (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .evt_i(evt),
    .sync_act_i(sync_act), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_ch_i(rd_ch), .rd_sel_i(rd_sel),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0]  m_flags [NCH];
  logic [5:0]  m_ien   [NCH];
  logic        m_sync  [NCH];
  logic [15:0] m_irq;
  logic        m_rv;
  logic [15:0] m_rd;
  string       cur_req = "R1";
  int          vecs = 0;
  int          bad = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exists_m(int c, bit ext);
    return ext || c < 9;
  endfunction

  function automatic int pair_m(int c);
    if (c < 3) return c + 6;
    if (c >= 6 && c < 9) return c - 6;
    return -1;
  endfunction

  function automatic bit nz_m(int c);
    return (m_flags[c] != 0) || m_sync[c];
  endfunction

  // one clock with the current inputs; model updated, outputs compared
  task automatic tick();
    bit legacy = !ext_mode;
    int rc = int'(rd_ch);
    int wc = int'(wr_ch);
    int p = pair_m(rc);
    bit sr;
    logic [15:0] nirq;
    logic [15:0] d;
    logic [5:0] nf;
    for (int l = 0; l < NCH; l++) begin
      if (legacy) nirq[l] = (l < 6) ? (nz_m(l) || (l < 3 && nz_m(l + 6))) : 1'b0;
      else        nirq[l] = nz_m(l);
    end
    sr = rd_en && !rd_sel && exists_m(rc, ext_mode);
    if (sr) nirq[(legacy && rc >= 6 && rc < 9) ? rc - 6 : rc] = 1'b0;
    d = '0;
    if (exists_m(rc, ext_mode)) begin
      if (!rd_sel) begin
        d = {9'b0, m_sync[rc], m_flags[rc]};
        if (legacy && p >= 0) d = d | {4'b0, m_flags[p], 6'b0};
      end else d = {10'b0, m_ien[rc]};
    end
    for (int c = 0; c < NCH; c++) begin
      nf = m_flags[c];
      if (sr && (c == rc || (legacy && p == c))) nf = '0;
      if (exists_m(c, ext_mode)) nf = nf | (evt[c*6 +: 6] & (m_ien[c] | 6'h02));
      m_flags[c] = nf;
      m_sync[c] = sync_act[c];
    end
    if (wr_en && wr_sel && exists_m(wc, ext_mode)) m_ien[wc] = wr_data;
    m_irq = nirq;
    m_rv = rd_en;
    if (rd_en) m_rd = d;
    @(posedge clk);
    @(negedge clk);
    check(cur_req, "irq", irq_o, m_irq);
    check("R6", "rd_valid", rd_valid_o, m_rv);
    if (m_rv) check(cur_req, "rd_data", rd_data_o, m_rd);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic pulse(int c, logic [5:0] bits);
    evt[c*6 +: 6] = bits;
    tick();
    evt = '0;
  endtask

  task automatic rd(int c, logic sel);
    rd_en = 1'b1; rd_ch = 4'(c); rd_sel = sel;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic wr(int c, logic sel, logic [5:0] data);
    wr_en = 1'b1; wr_ch = 4'(c); wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_flags[c] = '0; m_ien[c] = 6'h03; m_sync[c] = 1'b0;
    end
    m_irq = '0; m_rv = 1'b0; m_rd = '0;
    repeat (3) @(negedge clk);
    check("R1", "irq in reset", irq_o, 0);
    check("R1", "rd_valid in reset", rd_valid_o, 0);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R1";
    rd(0, 1'b1);
    check("R1", "enable reset", rd_data_o, 16'h0003);

    // masking with the reset mask, legacy mode
    cur_req = "R3";
    pulse(3, 6'h3F);
    idle(1);
    check("R9", "line 3 own", irq_o[3], 1);
    cur_req = "R7";
    rd(3, 1'b0);
    check("R3", "reset mask keeps tmo+drop", rd_data_o, 16'h0003);
    check("R11", "line lowered", irq_o[3], 0);
    idle(1);
    check("R7", "line stays low after clear", irq_o[3], 0);

    // enable write, status write ignored
    cur_req = "R13";
    wr(3, 1'b1, 6'h3C);
    pulse(3, 6'h01);
    wr(3, 1'b0, 6'h3F);
    rd(3, 1'b0);
    check("R13", "status write ignored", rd_data_o, 16'h0000);
    pulse(3, 6'h3F);
    rd(3, 1'b0);
    check("R4", "drop unmasked", rd_data_o, 16'h003E);

    // legacy pairing
    cur_req = "R8";
    pulse(7, 6'h02);
    pulse(1, 6'h01);
    idle(1);
    check("R9", "shared line 1", irq_o[1], 1);
    rd(1, 1'b0);
    check("R8", "partner field", rd_data_o, 16'h0081);
    rd(7, 1'b0);
    check("R8", "partner cleared", rd_data_o, 16'h0000);

    // sync bit survives, line re-raises
    cur_req = "R5";
    sync_act[2] = 1'b1;
    idle(2);
    rd(2, 1'b0);
    check("R5", "sync bit read", rd_data_o, 16'h0040);
    check("R11", "lowered on read", irq_o[2], 0);
    idle(1);
    check("R11", "re-raised by sync", irq_o[2], 1);
    rd(2, 1'b0);
    check("R5", "sync survives read", rd_data_o, 16'h0040);
    sync_act[2] = 1'b0;
    idle(2);

    // event colliding with clear
    cur_req = "R12";
    evt[4*6 +: 6] = 6'h02;
    rd(4, 1'b0);
    evt = '0;
    check("R12", "read before event", rd_data_o, 16'h0000);
    rd(4, 1'b0);
    check("R12", "event survived clear", rd_data_o, 16'h0002);

    // absent channels in legacy
    cur_req = "R14";
    pulse(12, 6'h3F);
    wr(12, 1'b1, 6'h00);
    rd(12, 1'b0);
    check("R14", "absent read", rd_data_o, 16'h0000);
    ext_mode = 1'b1;
    idle(2);
    rd(12, 1'b0);
    check("R14", "events were ignored", rd_data_o, 16'h0000);
    rd(12, 1'b1);
    check("R14", "write was ignored", rd_data_o, 16'h0003);

    // extended lines and registered timing
    cur_req = "R10";
    pulse(9, 6'h02);
    check("R10", "line not yet up", irq_o[9], 0);
    idle(1);
    check("R10", "line up one cycle later", irq_o[9], 1);
    cur_req = "R9";
    rd(9, 1'b0);
    check("R9", "ext own status", rd_data_o, 16'h0002);
    pulse(0, 6'h02);
    pulse(6, 6'h02);
    rd(0, 1'b0);
    check("R8", "no partner in ext", rd_data_o, 16'h0002);
    check("R9", "line 6 own in ext", irq_o[6], 1);

    // constrained random
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NCH; c++)
        evt[c*6 +: 6] = ($urandom_range(0, 11) == 0) ? 6'($urandom()) : 6'h00;
      if ($urandom_range(0, 39) == 0) sync_act[$urandom_range(0, 15)] ^= 1'b1;
      if ($urandom_range(0, 249) == 0) ext_mode = ~ext_mode;
      rd_en = ($urandom_range(0, 2) == 0);
      rd_ch = 4'($urandom());
      rd_sel = ($urandom_range(0, 3) == 0);
      wr_en = ($urandom_range(0, 9) == 0);
      wr_ch = 4'($urandom());
      wr_sel = 1'($urandom());
      wr_data = 6'($urandom());
      tick();
    end
    evt = '0; rd_en = 1'b0; wr_en = 1'b0;
    idle(2);
    finish_run();
  end
endmodule